// File: doc/BRIEF.md
# Precision-Configurable Vector Multiply-Accumulate Unit

This block is the integer multiply-accumulate stage of a vector datapath. Each issue presents two 512-bit operand vectors, X and Z, and a mode code. The mode says how the operands are read: real or complex elements, 16 or 32 bits wide. It also says how the 384-bit accumulator is read: eight 48-bit fields or four 80-bit fields. The products of each lane are summed and then either added to the accumulator or written over it.

All five modes share one array of thirty-two signed 17x17 multipliers. A 32-bit multiply is built from four 16-bit partial products. A complex multiply is built from four real products. The MAC count per issue therefore falls as the elements get wider or become complex. The result is registered, and a valid flag marks the cycle after each issue.

Top module: `vmac_unit`

## Requirements
- R1: While `rst_n` is low, `out_acc` is zero and `out_vld` is low.
- R2: `out_vld` equals `in_vld` from one clock earlier, and an issue changes `out_acc` at the clock edge that samples it.
- R3: Mode 0 (16-bit real by 16-bit real, 32 MACs). The accumulator is read as eight 48-bit lanes, lane L at bits [48L+47:48L]. Lane L sums the products X16[4L+t]*Z16[4L+t] for t = 0..3. Element i of an operand sits at bits [16i+15:16i].
- R4: Mode 1 (16-bit real by 16-bit complex, 16 MACs). There are four complex lanes. Lane C keeps its real part in 48-bit field 2C and its imaginary part in field 2C+1. For p = 2C and p = 2C+1, X16[p] times the real half of complex Z element p adds to the real part, and X16[p] times its imaginary half adds to the imaginary part. A 16-bit complex element p occupies bits [32p+31:32p], with the real half in the low 16 bits.
- R5: Mode 2 (16-bit complex by 16-bit complex, 8 MACs). Each of the four complex lanes sums the products of elements 2C and 2C+1. A product (a+jb)(c+jd) adds ac-bd to the real field and ad+bc to the imaginary field.
- R6: Mode 3 (32-bit real by 32-bit real, 8 MACs). The accumulator is read as four 80-bit lanes, lane L at bits [80L+79:80L]. Lane L sums X32[2L+t]*Z32[2L+t] for t = 0..1, where 32-bit element i sits at bits [32i+31:32i]. Bits [383:320] become zero after any issue in mode 3 or mode 4.
- R7: Mode 4 (32-bit complex by 32-bit complex, 2 MACs). There are two complex lanes. Lane C holds real field 2C and imaginary field 2C+1, each 80 bits wide. Each lane takes one product of complex elements C, which sit at bits [64C+63:64C] with the real half in the low 32 bits.
- R8: With `in_load` high, an issue writes the new lane sums in place of the old contents. With `in_load` low, it adds them to the old contents.
- R9: Products are sign-extended before they are summed. Each lane wraps modulo 2 to the power of its width, with no saturation and no carry into the next lane.
- R10: A cycle without an issue leaves `out_acc` unchanged, whatever values the mode and operand inputs hold.
- R11: An issue with a mode code of 5, 6 or 7 leaves `out_acc` unchanged. It still raises `out_vld` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Issue strobe |
| in_mode | input | 3 | Precision and lane mode code |
| in_load | input | 1 | 1 overwrites the accumulator, 0 adds to it |
| in_x | input | 512 | Operand vector X |
| in_z | input | 512 | Operand vector Z |
| out_acc | output | 384 | Registered accumulator |
| out_vld | output | 1 | Issue strobe delayed by one cycle |

## Verification
The hardest state to reach from the ports is a 48-bit lane wrapping past its signed limit. An issue adds at most 2^32 to a lane, so the stimulus first loads a lane and then accumulates the most negative 16-bit squares for 32,768 back-to-back issues. This drives every lane exactly onto the sign boundary, and the lanes are compared with fixed constants both there and one issue later. The 32-bit partial-product assembly is also hard to exercise, because only extreme words expose an error in the unsigned low halves. To reach it, every mode is swept over all pairs from a corner-value set that includes the minimum and maximum words. Each step is compared with an arithmetic model that multiplies whole elements directly.

// File: rtl/vmac_pkg.sv
// Package: shared widths, mode codes and arithmetic helpers for the vector MAC.
// Assumes the fixed 384-bit accumulator and 512-bit operand buses.
package vmac_pkg;

    localparam int ACC_W  = 384;            // accumulator width
    localparam int OPD_W  = 512;            // operand bus width
    localparam int NMUL   = 32;             // multipliers in the shared array
    localparam int MW     = 17;             // multiplier operand width
    localparam int PW     = 2 * MW;         // product width
    localparam int LN_S   = 48;             // short lane width
    localparam int LN_L   = 80;             // long lane width
    localparam int NL_S   = ACC_W / LN_S;   // short lanes (8)
    localparam int NL_L   = ACC_W / LN_L;   // long lanes (4)
    localparam int PAD_L  = ACC_W - NL_L * LN_L; // unused bits in long view

    typedef enum logic [2:0] {
        VM_RR16 = 3'd0,
        VM_RC16 = 3'd1,
        VM_CC16 = 3'd2,
        VM_RR32 = 3'd3,
        VM_CC32 = 3'd4
    } vmac_mode_e;

    // Sign-extend a 16-bit element to multiplier width.
    function automatic logic [MW-1:0] sx16(input logic [15:0] v);
        return {v[15], v};
    endfunction

    // Pick one half of a 32-bit word: signed upper half or unsigned lower half.
    function automatic logic [MW-1:0] half32(input logic [31:0] w, input logic hi);
        return hi ? {w[31], w[31:16]} : {1'b0, w[15:0]};
    endfunction

    // Sign-extend a product to long-lane width.
    function automatic logic [LN_L-1:0] sxp(input logic [PW-1:0] p);
        return {{(LN_L-PW){p[PW-1]}}, p};
    endfunction

    // Rebuild a 32x32 product from its four 16-bit partial products.
    function automatic logic [LN_L-1:0] join32(input logic [PW-1:0] hh,
                                               input logic [PW-1:0] hl,
                                               input logic [PW-1:0] lh,
                                               input logic [PW-1:0] ll);
        return (sxp(hh) << 32) + (sxp(hl) << 16) + (sxp(lh) << 16) + sxp(ll);
    endfunction

endpackage

// File: rtl/vmac_opsel.sv
// Module: operand steering. For each multiplier it picks the 17-bit X and Z
// slices that the current mode assigns to it. Multipliers a mode does not
// use receive zero. Assumes element packing as stated in the brief.
module vmac_opsel
    import vmac_pkg::*;
(
    input  logic [2:0]               mode,
    input  logic [OPD_W-1:0]         x,
    input  logic [OPD_W-1:0]         z,
    output logic [NMUL-1:0][MW-1:0]  opa,
    output logic [NMUL-1:0][MW-1:0]  opb
);

    // Steer operand slices into every multiplier according to the mode.
    always_comb begin
        for (int k = 0; k < NMUL; k++) begin
            logic [31:0] xw;
            logic [31:0] zw;
            int          j;
            int          q;
            xw     = '0;
            zw     = '0;
            j      = k % 4;
            q      = (k / 4) % 4;
            opa[k] = '0;
            opb[k] = '0;
            case (vmac_mode_e'(mode))
                VM_RR16: begin
                    opa[k] = sx16(x[16*k +: 16]);
                    opb[k] = sx16(z[16*k +: 16]);
                end
                VM_RC16: begin
                    if (k < NMUL/2) begin
                        opa[k] = sx16(x[16*(k/2) +: 16]);
                        opb[k] = sx16(z[32*(k/2) + 16*(k%2) +: 16]);
                    end
                end
                VM_CC16: begin
                    xw     = x[32*(k/4) +: 32];
                    zw     = z[32*(k/4) +: 32];
                    opa[k] = sx16((j == 1 || j == 3) ? xw[31:16] : xw[15:0]);
                    opb[k] = sx16((j == 1 || j == 2) ? zw[31:16] : zw[15:0]);
                end
                VM_RR32: begin
                    xw     = x[32*(k/4) +: 32];
                    zw     = z[32*(k/4) +: 32];
                    opa[k] = half32(xw, j < 2);
                    opb[k] = half32(zw, j == 0 || j == 2);
                end
                VM_CC32: begin
                    xw     = (q == 1 || q == 3) ? x[64*(k/16) + 32 +: 32] : x[64*(k/16) +: 32];
                    zw     = (q == 1 || q == 2) ? z[64*(k/16) + 32 +: 32] : z[64*(k/16) +: 32];
                    opa[k] = half32(xw, j < 2);
                    opb[k] = half32(zw, j == 0 || j == 2);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vmac_mularray.sv
// Module: shared array of signed multipliers. It is mode-agnostic and only
// assumes that its operands arrive already sign- or zero-extended.
module vmac_mularray
    import vmac_pkg::*;
(
    input  logic [NMUL-1:0][MW-1:0]  opa,
    input  logic [NMUL-1:0][MW-1:0]  opb,
    output logic [NMUL-1:0][PW-1:0]  prod
);

    // One signed multiplier per array slot.
    for (genvar g = 0; g < NMUL; g++) begin : g_mul
        assign prod[g] = $signed(opa[g]) * $signed(opb[g]);
    end

endmodule

// File: rtl/vmac_reduce.sv
// Module: lane reduction. It joins partial products, forms the complex real
// and imaginary terms and sums each lane into a per-field increment. The
// increment is laid out in the accumulator view of the mode. It assumes the
// multiplier slot assignment used by vmac_opsel.
module vmac_reduce
    import vmac_pkg::*;
(
    input  logic [2:0]               mode,
    input  logic [NMUL-1:0][PW-1:0]  prod,
    output logic [ACC_W-1:0]         inc
);

    // Build the lane increments for the selected mode.
    always_comb begin
        logic [LN_L-1:0] sr;
        logic [LN_L-1:0] si;
        inc = '0;
        sr  = '0;
        si  = '0;
        case (vmac_mode_e'(mode))
            VM_RR16: begin
                for (int f = 0; f < NL_S; f++) begin
                    sr = '0;
                    for (int t = 0; t < 4; t++) sr = sr + sxp(prod[4*f+t]);
                    inc[LN_S*f +: LN_S] = sr[LN_S-1:0];
                end
            end
            VM_RC16: begin
                for (int c = 0; c < NL_S/2; c++) begin
                    sr = '0;
                    si = '0;
                    for (int t = 0; t < 2; t++) begin
                        sr = sr + sxp(prod[2*(2*c+t)]);
                        si = si + sxp(prod[2*(2*c+t)+1]);
                    end
                    inc[LN_S*(2*c)   +: LN_S] = sr[LN_S-1:0];
                    inc[LN_S*(2*c+1) +: LN_S] = si[LN_S-1:0];
                end
            end
            VM_CC16: begin
                for (int c = 0; c < NL_S/2; c++) begin
                    sr = '0;
                    si = '0;
                    for (int t = 0; t < 2; t++) begin
                        sr = sr + sxp(prod[4*(2*c+t)])   - sxp(prod[4*(2*c+t)+1]);
                        si = si + sxp(prod[4*(2*c+t)+2]) + sxp(prod[4*(2*c+t)+3]);
                    end
                    inc[LN_S*(2*c)   +: LN_S] = sr[LN_S-1:0];
                    inc[LN_S*(2*c+1) +: LN_S] = si[LN_S-1:0];
                end
            end
            VM_RR32: begin
                for (int f = 0; f < NL_L; f++) begin
                    sr = '0;
                    for (int t = 0; t < 2; t++) begin
                        sr = sr + join32(prod[4*(2*f+t)],   prod[4*(2*f+t)+1],
                                         prod[4*(2*f+t)+2], prod[4*(2*f+t)+3]);
                    end
                    inc[LN_L*f +: LN_L] = sr;
                end
            end
            VM_CC32: begin
                for (int c = 0; c < NL_L/2; c++) begin
                    sr = join32(prod[16*c],    prod[16*c+1],  prod[16*c+2],  prod[16*c+3])
                       - join32(prod[16*c+4],  prod[16*c+5],  prod[16*c+6],  prod[16*c+7]);
                    si = join32(prod[16*c+8],  prod[16*c+9],  prod[16*c+10], prod[16*c+11])
                       + join32(prod[16*c+12], prod[16*c+13], prod[16*c+14], prod[16*c+15]);
                    inc[LN_L*(2*c)   +: LN_L] = sr;
                    inc[LN_L*(2*c+1) +: LN_L] = si;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vmac_unit.sv
// Module: top of the vector MAC. Operand steering, the multiplier array and
// lane reduction feed per-lane adders in both lane views. The selected view
// is registered on an issue. Assumes the synchronous active-low reset.
module vmac_unit
    import vmac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic [2:0]         in_mode,
    input  logic               in_load,
    input  logic [OPD_W-1:0]   in_x,
    input  logic [OPD_W-1:0]   in_z,
    output logic [ACC_W-1:0]   out_acc,
    output logic               out_vld
);

    logic [NMUL-1:0][MW-1:0]  opa;
    logic [NMUL-1:0][MW-1:0]  opb;
    logic [NMUL-1:0][PW-1:0]  prod;
    logic [ACC_W-1:0]         inc;
    logic [ACC_W-1:0]         acc_q;
    logic                     vld_q;
    logic [ACC_W-1:0]         base;
    logic [ACC_W-1:0]         nx_s;
    logic [ACC_W-1:0]         nx_l;
    logic                     legal;
    logic                     long_view;

    vmac_opsel u_opsel (
        .mode (in_mode),
        .x    (in_x),
        .z    (in_z),
        .opa  (opa),
        .opb  (opb)
    );

    vmac_mularray u_mul (
        .opa  (opa),
        .opb  (opb),
        .prod (prod)
    );

    vmac_reduce u_red (
        .mode (in_mode),
        .prod (prod),
        .inc  (inc)
    );

    // Load clears the addend, accumulate keeps the current contents.
    assign base = in_load ? '0 : acc_q;

    // Short-lane adders, each wrapping at its own width.
    for (genvar g = 0; g < NL_S; g++) begin : g_add_s
        assign nx_s[LN_S*g +: LN_S] = base[LN_S*g +: LN_S] + inc[LN_S*g +: LN_S];
    end

    // Long-lane adders, each wrapping at its own width.
    for (genvar g = 0; g < NL_L; g++) begin : g_add_l
        assign nx_l[LN_L*g +: LN_L] = base[LN_L*g +: LN_L] + inc[LN_L*g +: LN_L];
    end
    assign nx_l[ACC_W-1 -: PAD_L] = '0;

    // Classify the mode code into legality and lane view.
    always_comb begin
        legal     = (in_mode <= 3'(VM_CC32));
        long_view = (in_mode == 3'(VM_RR32)) || (in_mode == 3'(VM_CC32));
    end

    // Accumulator and valid registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_vld;
            if (in_vld && legal) acc_q <= long_view ? nx_l : nx_s;
        end
    end

    assign out_acc = acc_q;
    assign out_vld = vld_q;

endmodule

// File: rtl/vmac_unit_chk.sv
// Module: port-level checker for vmac_unit, attached through bind.
module vmac_unit_chk
    import vmac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic [2:0]         in_mode,
    input  logic               in_load,
    input  logic [OPD_W-1:0]   in_x,
    input  logic [OPD_W-1:0]   in_z,
    input  logic [ACC_W-1:0]   out_acc,
    input  logic               out_vld
);

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_vld == $past(in_vld)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_vld)) |-> $stable(out_acc));

    // R11
    reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_vld) && ($past(in_mode) > 3'd4)) |-> $stable(out_acc));

    // R6
    long_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_vld) && (($past(in_mode) == 3'd3) || ($past(in_mode) == 3'd4)))
        |-> (out_acc[ACC_W-1 -: PAD_L] == '0));

    // R8
    load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_vld) && $past(in_load) && ($past(in_mode) <= 3'd4)
         && ($past(in_x) == '0)) |-> (out_acc == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (out_acc == '0 && !out_vld));

    logic unused_z;
    assign unused_z = ^in_z;

endmodule

bind vmac_unit vmac_unit_chk u_vmac_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_mode (in_mode),
    .in_load (in_load),
    .in_x    (in_x),
    .in_z    (in_z),
    .out_acc (out_acc),
    .out_vld (out_vld)
);

// File: tb/vmac_unit_bench.sv
`timescale 1ns/1ps
module vmac_unit_bench;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [2:0]    in_mode = 3'd0;
    logic          in_load = 1'b0;
    logic [511:0]  in_x = '0;
    logic [511:0]  in_z = '0;
    logic [383:0]  out_acc;
    logic          out_vld;

    int checks = 0;
    int failures = 0;
    logic [383:0] exp_acc = '0;

    always #2.5 clk = ~clk;

    vmac_unit u_vmac_unit (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mode(in_mode),
        .in_load(in_load), .in_x(in_x), .in_z(in_z),
        .out_acc(out_acc), .out_vld(out_vld)
    );

    // Arithmetic model: whole-element products, lane sums wrap by truncation.
    function automatic logic [383:0] ref_next(input logic [383:0] acc, input logic [2:0] m,
                                              input logic ld, input logic [511:0] x,
                                              input logic [511:0] z);
        logic [383:0] r;
        logic signed [79:0] sr, si, a, ai, b, bi;
        r = acc;
        case (m)
            3'd0: for (int f = 0; f < 8; f++) begin
                sr = 0;
                for (int t = 0; t < 4; t++) begin
                    a = $signed(x[16*(4*f+t) +: 16]); b = $signed(z[16*(4*f+t) +: 16]);
                    sr = sr + a * b;
                end
                r[48*f +: 48] = (ld ? 48'd0 : acc[48*f +: 48]) + sr[47:0];
            end
            3'd1, 3'd2: for (int c = 0; c < 4; c++) begin
                sr = 0; si = 0;
                for (int t = 0; t < 2; t++) begin
                    int p;
                    p = 2*c + t;
                    b  = $signed(z[32*p +: 16]); bi = $signed(z[32*p+16 +: 16]);
                    if (m == 3'd1) begin
                        a = $signed(x[16*p +: 16]);
                        sr = sr + a * b; si = si + a * bi;
                    end else begin
                        a = $signed(x[32*p +: 16]); ai = $signed(x[32*p+16 +: 16]);
                        sr = sr + a * b - ai * bi; si = si + a * bi + ai * b;
                    end
                end
                r[48*(2*c)   +: 48] = (ld ? 48'd0 : acc[48*(2*c)   +: 48]) + sr[47:0];
                r[48*(2*c+1) +: 48] = (ld ? 48'd0 : acc[48*(2*c+1) +: 48]) + si[47:0];
            end
            3'd3: begin
                r[383:320] = '0;
                for (int f = 0; f < 4; f++) begin
                    sr = 0;
                    for (int t = 0; t < 2; t++) begin
                        a = $signed(x[32*(2*f+t) +: 32]); b = $signed(z[32*(2*f+t) +: 32]);
                        sr = sr + a * b;
                    end
                    r[80*f +: 80] = (ld ? 80'd0 : acc[80*f +: 80]) + sr;
                end
            end
            3'd4: begin
                r[383:320] = '0;
                for (int c = 0; c < 2; c++) begin
                    a = $signed(x[64*c +: 32]); ai = $signed(x[64*c+32 +: 32]);
                    b = $signed(z[64*c +: 32]); bi = $signed(z[64*c+32 +: 32]);
                    sr = a * b - ai * bi; si = a * bi + ai * b;
                    r[80*(2*c)   +: 80] = (ld ? 80'd0 : acc[80*(2*c)   +: 80]) + sr;
                    r[80*(2*c+1) +: 80] = (ld ? 80'd0 : acc[80*(2*c+1) +: 80]) + si;
                end
            end
            default: r = acc;
        endcase
        return r;
    endfunction

    function automatic logic [15:0] c16(input int i);
        case (i % 6)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'hFFFF;
            3: return 16'h7FFF;  4: return 16'h8000;  default: return 16'h5A3C;
        endcase
    endfunction

    function automatic logic [31:0] c32(input int i);
        case (i % 6)
            0: return 32'h0;         1: return 32'h1;         2: return 32'hFFFFFFFF;
            3: return 32'h7FFFFFFF;  4: return 32'h80000000;  default: return 32'h1234ABCD;
        endcase
    endfunction

    function automatic logic [511:0] fill(input logic wide, input int s, input int step);
        logic [511:0] v;
        v = '0;
        for (int e = 0; e < 32; e++) begin
            if (wide) begin
                if (e < 16) v[32*e +: 32] = c32(s + step*e);
            end else v[16*e +: 16] = c16(s + step*e);
        end
        return v;
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int e = 0; e < 16; e++) v[32*e +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk_acc(input string req, input logic [383:0] exp);
        checks++;
        if (out_acc !== exp) begin
            failures++;
            $display("FAIL %s acc actual=%h expected=%h", req, out_acc, exp);
        end
    endtask

    task automatic chk_vld(input string req, input logic exp);
        checks++;
        if (out_vld !== exp) begin
            failures++;
            $display("FAIL %s vld actual=%b expected=%b", req, out_vld, exp);
        end
    endtask

    // Drive one issue at a falling edge; check at the next falling edge.
    task automatic issue(input logic [2:0] m, input logic ld, input logic [511:0] x,
                         input logic [511:0] z, input string req, input bit do_chk);
        in_vld = 1'b1; in_mode = m; in_load = ld; in_x = x; in_z = z;
        exp_acc = ref_next(exp_acc, m, ld, x, z);
        @(posedge clk); @(negedge clk);
        if (do_chk) begin
            chk_acc(req, exp_acc);
            chk_vld("R2", 1'b1);
        end
    endtask

    task automatic idle_cycle(input string req);
        in_vld = 1'b0; in_mode = 3'($urandom); in_load = 1'($urandom);
        in_x = rnd512(); in_z = rnd512();
        @(posedge clk); @(negedge clk);
        chk_acc(req, exp_acc);
        chk_vld("R2", 1'b0);
    endtask

    string mreq [5] = '{"R3", "R4", "R5", "R6", "R7"};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk_acc("R1", '0);
        chk_vld("R1", 1'b0);
        rst_n = 1'b1;
        idle_cycle("R10");

        // R3..R7: corner sweeps over each mode, back-to-back accumulation
        for (int m = 0; m < 5; m++) begin
            for (int ia = 0; ia < 6; ia++) begin
                for (int ib = 0; ib < 6; ib++) begin
                    issue(3'(m), (ia == 0 && ib == 0), fill(m >= 3, ia, 1),
                          fill(m >= 3, ib, 5), mreq[m], 1'b1);
                end
            end
            idle_cycle("R10");
            for (int n = 0; n < 40; n++)
                issue(3'(m), (n % 13 == 0), rnd512(), rnd512(), mreq[m], 1'b1);
            idle_cycle("R10");
        end

        // R8: load replaces old contents after a run of accumulations
        for (int n = 0; n < 5; n++) issue(3'd0, 1'b0, rnd512(), rnd512(), "R8", 1'b1);
        issue(3'd0, 1'b1, fill(1'b0, 1, 0), fill(1'b0, 3, 0), "R8", 1'b1);
        // every lane is 4 * 1 * 0x7FFF
        chk_acc("R8", {8{48'h0000_0001_FFFC}});
        issue(3'd2, 1'b0, rnd512(), rnd512(), "R8", 1'b1);

        // R11: reserved codes leave accumulator untouched, valid still pulses
        for (int m = 5; m < 8; m++) issue(3'(m), 1'($urandom), rnd512(), rnd512(), "R11", 1'b1);
        idle_cycle("R10");
        for (int n = 0; n < 20; n++) idle_cycle("R10");

        // R9: drive every short lane across the sign boundary
        issue(3'd0, 1'b1, {32{16'h8000}}, {32{16'h8000}}, "R9", 1'b1);
        for (int n = 1; n < 32768; n++)
            issue(3'd0, 1'b0, {32{16'h8000}}, {32{16'h8000}}, "R9", 1'b0);
        chk_acc("R9", {8{48'h8000_0000_0000}});
        issue(3'd0, 1'b0, {32{16'h8000}}, {32{16'h8000}}, "R9", 1'b1);
        chk_acc("R9", {8{48'h8001_0000_0000}});
        // R6: long view after short view clears the pad bits
        issue(3'd3, 1'b0, rnd512(), rnd512(), "R6", 1'b1);
        idle_cycle("R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule